// File: doc/BRIEF.md
# Split-Capable Carry-Select Chain for a Ten-Element Logic Cluster

This block models the carry path of one logic cluster of ten arithmetic elements. Each element adds two operand bits, so the cluster covers a 20-bit slice. Inside an element the carry comes from a two-bit carry-select group. The group computes its result for an incoming carry of 0 and for an incoming carry of 1, then picks one result with the real carry. The carry therefore passes through only one multiplexer per element instead of two ripple stages.

Elements 0 to 4 form the top half and hold operand bits 9:0, with element 0 holding bits 1:0. Elements 5 to 9 form the bottom half and hold bits 19:10. In full mode a single chain runs through the cluster. It starts at element 0, or at element 5 when the mid start is selected. In split mode each half is its own chain with its own carry-in, and its carry-out goes on to the matching half of the next cluster in the column. Clusters are joined by connecting `coutTopQ` and `coutBotQ` of one cluster to `cinTop` and `cinBot` of the next. A half that is not used can be set to bypass. Its carry-in then goes straight to its carry-out and its sum bits read zero.

The sums and both carry-outs are registered once, so the outputs can drive general routing.

Top module: `cluster_carry_chain`

## Requirements
- R1: While `rstN` is low, `sumQ`, `coutTopQ` and `coutBotQ` are all zero, and they clear without waiting for a clock edge.
- R2: The outputs take their new values at the rising clock edge after the inputs are applied and do not change before that edge.
- R3: Full mode (`cfgHalf`=0) with `cfgStartMid`=0 and no bypass: {`coutBotQ`,`sumQ`} = `opA` + `opB` + `cinTop` over 20 bits, and `coutTopQ` is the carry out of bits 9:0.
- R4: Full mode with `cfgStartMid`=1: the top half adds bits 9:0 with an incoming carry of 0 and drives `coutTopQ`. The bottom half adds bits 19:10 with `cinTop` as its incoming carry and drives `coutBotQ`.
- R5: Split mode (`cfgHalf`=1): the top half adds bits 9:0 with `cinTop` and drives `coutTopQ`. The bottom half adds bits 19:10 with `cinBot` and drives `coutBotQ`. Neither half affects the other.
- R6: `cfgBypassTop`=1: `sumQ[9:0]` reads zero and `coutTopQ` equals the top half's incoming carry. In full mode with start at element 0, that carry then enters the bottom half.
- R7: `cfgBypassBot`=1: `sumQ[19:10]` reads zero and `coutBotQ` equals the bottom half's incoming carry.
- R8: A carry travels through every two-bit group and across the half boundary. With all-ones `opA`, zero `opB` and an incoming carry of 1, every covered sum bit is 0 and the carry-out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 20 | First operand, element k holds bits 2k+1:2k |
| opB | input | 20 | Second operand, same layout |
| cinTop | input | 1 | Carry into the top half (the cluster chain entry in full mode) |
| cinBot | input | 1 | Carry into the bottom half, used in split mode |
| cfgHalf | input | 1 | 1 = split mode, 0 = full mode |
| cfgStartMid | input | 1 | Full mode only: 1 = chain starts at element 5 |
| cfgBypassTop | input | 1 | Top half passes its carry through and outputs zero sums |
| cfgBypassBot | input | 1 | Bottom half passes its carry through and outputs zero sums |
| sumQ | output | 20 | Registered sum bits |
| coutTopQ | output | 1 | Registered carry-out of the top half |
| coutBotQ | output | 1 | Registered carry-out of the bottom half |

## Verification
The assertions check on every cycle the cases that can be written as closed arithmetic: the 20-bit full-chain sum, the independent sum of the bottom half in split mode, zero sums and carry pass-through in bypassed halves, and the cleared outputs during reset. The start-at-element-5 routing, a bypassed top half feeding the bottom half in full mode, the long carry runs across every group, a reset in the middle of traffic and the one-cycle timing are shown only by the bench's scenarios, which compare against its own behavioural model.

// File: rtl/cluster_carry_pkg.sv
package cluster_carry_pkg;

  // Source of the carry that enters a half of the cluster
  typedef enum logic [1:0] {
    SRC_ZERO     = 2'd0,
    SRC_CIN_TOP  = 2'd1,
    SRC_CIN_BOT  = 2'd2,
    SRC_TOP_COUT = 2'd3
  } carrySrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    carrySrc_e topSrc;
    carrySrc_e botSrc;
    logic      bypassTop;
    logic      bypassBot;
  } chainCtl_t;

endpackage

// File: rtl/carry_select_pair.sv
// One element: precomputes both carry outcomes, then selects with the live carry.
module carry_select_pair #(
  parameter int BITS = 2
) (
  input  logic [BITS-1:0] a,
  input  logic [BITS-1:0] b,
  input  logic            cin,
  output logic [BITS-1:0] sum,
  output logic            cout
);
  logic [BITS:0] resCin0;
  logic [BITS:0] resCin1;

  always_comb begin
    resCin0 = {1'b0, a} + {1'b0, b};
    resCin1 = {1'b0, a} + {1'b0, b} + (BITS+1)'(1);
  end

  assign sum  = cin ? resCin1[BITS-1:0] : resCin0[BITS-1:0];
  assign cout = cin ? resCin1[BITS]     : resCin0[BITS];
endmodule

// File: rtl/carry_half_chain.sv
// A run of elements forming one half of the cluster, with bypass.
module carry_half_chain #(
  parameter int ELEMS_H   = 5,
  parameter int ELEM_BITS = 2
) (
  input  logic [ELEMS_H*ELEM_BITS-1:0] a,
  input  logic [ELEMS_H*ELEM_BITS-1:0] b,
  input  logic                         cin,
  input  logic                         bypass,
  output logic [ELEMS_H*ELEM_BITS-1:0] sum,
  output logic                         cout
);
  localparam int HW = ELEMS_H * ELEM_BITS;

  logic [ELEMS_H:0] link;
  logic [HW-1:0]    rawSum;

  assign link[0] = cin;

  for (genvar g = 0; g < ELEMS_H; g++) begin : gElem
    carry_select_pair #(.BITS(ELEM_BITS)) uPair (
      .a   (a[g*ELEM_BITS +: ELEM_BITS]),
      .b   (b[g*ELEM_BITS +: ELEM_BITS]),
      .cin (link[g]),
      .sum (rawSum[g*ELEM_BITS +: ELEM_BITS]),
      .cout(link[g+1])
    );
  end

  assign sum  = bypass ? '0  : rawSum;
  assign cout = bypass ? cin : link[ELEMS_H];
endmodule

// File: rtl/cluster_carry_ctrl.sv
// Decodes the mode configuration into carry-source strobes.
module cluster_carry_ctrl
  import cluster_carry_pkg::*;
(
  input  logic      cfgHalf,
  input  logic      cfgStartMid,
  input  logic      cfgBypassTop,
  input  logic      cfgBypassBot,
  output chainCtl_t ctl
);
  always_comb begin
    ctl.bypassTop = cfgBypassTop;
    ctl.bypassBot = cfgBypassBot;
    if (cfgHalf) begin
      ctl.topSrc = SRC_CIN_TOP;
      ctl.botSrc = SRC_CIN_BOT;
    end else if (cfgStartMid) begin
      ctl.topSrc = SRC_ZERO;
      ctl.botSrc = SRC_CIN_TOP;
    end else begin
      ctl.topSrc = SRC_CIN_TOP;
      ctl.botSrc = SRC_TOP_COUT;
    end
  end
endmodule

// File: rtl/cluster_carry_dp.sv
// Two half chains, carry-entry muxes and output registers.
module cluster_carry_dp
  import cluster_carry_pkg::*;
#(
  parameter int ELEMS     = 10,
  parameter int ELEM_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ELEMS*ELEM_BITS-1:0] opA,
  input  logic [ELEMS*ELEM_BITS-1:0] opB,
  input  logic                       cinTop,
  input  logic                       cinBot,
  input  chainCtl_t                  ctl,
  output logic [ELEMS*ELEM_BITS-1:0] sumQ,
  output logic                       coutTopQ,
  output logic                       coutBotQ
);
  localparam int HALF_ELEMS = ELEMS / 2;
  localparam int W          = ELEMS * ELEM_BITS;
  localparam int HW         = HALF_ELEMS * ELEM_BITS;

  logic          topEntry, botEntry;
  logic          topOut, botOut;
  logic [HW-1:0] topSum, botSum;

  function automatic logic pickCarry(carrySrc_e src, logic cT, logic cB, logic cOut);
    case (src)
      SRC_CIN_TOP:  return cT;
      SRC_CIN_BOT:  return cB;
      SRC_TOP_COUT: return cOut;
      default:      return 1'b0;
    endcase
  endfunction

  assign topEntry = pickCarry(ctl.topSrc, cinTop, cinBot, 1'b0);
  assign botEntry = pickCarry(ctl.botSrc, cinTop, cinBot, topOut);

  carry_half_chain #(.ELEMS_H(HALF_ELEMS), .ELEM_BITS(ELEM_BITS)) uTop (
    .a     (opA[HW-1:0]),
    .b     (opB[HW-1:0]),
    .cin   (topEntry),
    .bypass(ctl.bypassTop),
    .sum   (topSum),
    .cout  (topOut)
  );

  carry_half_chain #(.ELEMS_H(HALF_ELEMS), .ELEM_BITS(ELEM_BITS)) uBot (
    .a     (opA[W-1:HW]),
    .b     (opB[W-1:HW]),
    .cin   (botEntry),
    .bypass(ctl.bypassBot),
    .sum   (botSum),
    .cout  (botOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ     <= '0;
      coutTopQ <= 1'b0;
      coutBotQ <= 1'b0;
    end else begin
      sumQ     <= {botSum, topSum};
      coutTopQ <= topOut;
      coutBotQ <= botOut;
    end
  end
endmodule

// File: rtl/cluster_carry_chain.sv
module cluster_carry_chain
  import cluster_carry_pkg::*;
#(
  parameter int ELEMS     = 10,
  parameter int ELEM_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ELEMS*ELEM_BITS-1:0] opA,
  input  logic [ELEMS*ELEM_BITS-1:0] opB,
  input  logic                       cinTop,
  input  logic                       cinBot,
  input  logic                       cfgHalf,
  input  logic                       cfgStartMid,
  input  logic                       cfgBypassTop,
  input  logic                       cfgBypassBot,
  output logic [ELEMS*ELEM_BITS-1:0] sumQ,
  output logic                       coutTopQ,
  output logic                       coutBotQ
);
  chainCtl_t ctl;

  cluster_carry_ctrl uCtrl (
    .cfgHalf     (cfgHalf),
    .cfgStartMid (cfgStartMid),
    .cfgBypassTop(cfgBypassTop),
    .cfgBypassBot(cfgBypassBot),
    .ctl         (ctl)
  );

  cluster_carry_dp #(.ELEMS(ELEMS), .ELEM_BITS(ELEM_BITS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .cinTop  (cinTop),
    .cinBot  (cinBot),
    .ctl     (ctl),
    .sumQ    (sumQ),
    .coutTopQ(coutTopQ),
    .coutBotQ(coutBotQ)
  );
endmodule

// File: rtl/cluster_carry_chain_chk.sv
module cluster_carry_chain_chk #(
  parameter int ELEMS     = 10,
  parameter int ELEM_BITS = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [ELEMS*ELEM_BITS-1:0] opA,
  input logic [ELEMS*ELEM_BITS-1:0] opB,
  input logic                       cinTop,
  input logic                       cinBot,
  input logic                       cfgHalf,
  input logic                       cfgStartMid,
  input logic                       cfgBypassTop,
  input logic                       cfgBypassBot,
  input logic [ELEMS*ELEM_BITS-1:0] sumQ,
  input logic                       coutTopQ,
  input logic                       coutBotQ
);
  localparam int W  = ELEMS * ELEM_BITS;
  localparam int HW = (ELEMS / 2) * ELEM_BITS;

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (rstN === 1'b0) begin
      a_r1_reset_clear: assert (sumQ == '0 && !coutTopQ && !coutBotQ)
        else $error("outputs not cleared in reset");
    end
  end

  // R3: full 20-bit add from element 0
  a_r3_full_sum: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(!cfgHalf && !cfgStartMid && !cfgBypassTop && !cfgBypassBot))
    |-> ({coutBotQ, sumQ} == (W+1)'($past(opA)) + (W+1)'($past(opB)) + (W+1)'($past(cinTop))));

  // R5: bottom half independent in split mode
  a_r5_split_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(cfgHalf && !cfgBypassBot))
    |-> ({coutBotQ, sumQ[W-1:HW]} == (W-HW+1)'($past(opA[W-1:HW])) +
          (W-HW+1)'($past(opB[W-1:HW])) + (W-HW+1)'($past(cinBot))));

  // R6: bypassed top half outputs zero sums
  a_r6_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(cfgBypassTop)) |-> (sumQ[HW-1:0] == '0));

  // R6: bypassed top half forwards cinTop when it is the entry carry
  a_r6_top_pass: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(cfgBypassTop && (cfgHalf || !cfgStartMid)))
    |-> (coutTopQ == $past(cinTop)));

  // R7: bypassed bottom half outputs zero sums
  a_r7_bot_zero: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(cfgBypassBot)) |-> (sumQ[W-1:HW] == '0));

  // R7: bypassed bottom half in split mode forwards cinBot
  a_r7_bot_pass: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(cfgHalf && cfgBypassBot)) |-> (coutBotQ == $past(cinBot)));
endmodule

bind cluster_carry_chain cluster_carry_chain_chk #(.ELEMS(ELEMS), .ELEM_BITS(ELEM_BITS)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .opA         (opA),
  .opB         (opB),
  .cinTop      (cinTop),
  .cinBot      (cinBot),
  .cfgHalf     (cfgHalf),
  .cfgStartMid (cfgStartMid),
  .cfgBypassTop(cfgBypassTop),
  .cfgBypassBot(cfgBypassBot),
  .sumQ        (sumQ),
  .coutTopQ    (coutTopQ),
  .coutBotQ    (coutBotQ)
);

// File: tb/cluster_carry_chain_test.sv
module cluster_carry_chain_test;
  localparam int ELEMS = 10;
  localparam int EB    = 2;
  localparam int W     = ELEMS * EB;
  localparam int HW    = W / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN;
  logic [W-1:0]  opA, opB;
  logic          cinTop, cinBot, cfgHalf, cfgStartMid, cfgBypassTop, cfgBypassBot;
  logic [W-1:0]  sumQ;
  logic          coutTopQ, coutBotQ;

  cluster_carry_chain #(.ELEMS(ELEMS), .ELEM_BITS(EB)) uut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .cinTop(cinTop), .cinBot(cinBot),
    .cfgHalf(cfgHalf), .cfgStartMid(cfgStartMid), .cfgBypassTop(cfgBypassTop),
    .cfgBypassBot(cfgBypassBot), .sumQ(sumQ), .coutTopQ(coutTopQ), .coutBotQ(coutBotQ)
  );

  typedef struct {
    logic [W-1:0] sum;
    logic         ct;
    logic         cb;
    string        tag;
  } expect_t;

  expect_t pending[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Behavioural reference: integer arithmetic per half
  function automatic expect_t refModel(logic [W-1:0] a, logic [W-1:0] b, logic ct, logic cb,
                                       logic half, logic mid, logic byT, logic byB, string tag);
    expect_t e;
    int unsigned aLo = int'(a[HW-1:0]), bLo = int'(b[HW-1:0]);
    int unsigned aHi = int'(a[W-1:HW]), bHi = int'(b[W-1:HW]);
    int unsigned lim = 1 << HW;
    int unsigned tot;
    int unsigned entT, entB, outT, sumT, sumB, outB;
    entT = (!half && mid) ? 0 : int'(ct);
    if (byT) begin sumT = 0; outT = entT; end
    else begin tot = aLo + bLo + entT; sumT = tot % lim; outT = tot / lim; end
    entB = half ? int'(cb) : (mid ? int'(ct) : outT);
    if (byB) begin sumB = 0; outB = entB; end
    else begin tot = aHi + bHi + entB; sumB = tot % lim; outB = tot / lim; end
    e.sum = {HW'(sumB), HW'(sumT)};
    e.ct  = outT[0];
    e.cb  = outB[0];
    e.tag = tag;
    return e;
  endfunction

  task automatic compareOut(expect_t e);
    vectors++;
    if (sumQ !== e.sum || coutTopQ !== e.ct || coutBotQ !== e.cb) begin
      miscompares++;
      $display("FAIL %s: sum=%h ct=%b cb=%b expected sum=%h ct=%b cb=%b",
               e.tag, sumQ, coutTopQ, coutBotQ, e.sum, e.ct, e.cb);
    end
  endtask

  // Compare the pending result, then drive a new vector
  task automatic step(logic [W-1:0] a, logic [W-1:0] b, logic ct, logic cb,
                      logic half, logic mid, logic byT, logic byB, string tag);
    expect_t hold;
    @(negedge clk);
    if (pending.size() > 0) compareOut(pending.pop_front());
    hold.sum = sumQ; hold.ct = coutTopQ; hold.cb = coutBotQ; hold.tag = "R2";
    opA = a; opB = b; cinTop = ct; cinBot = cb;
    cfgHalf = half; cfgStartMid = mid; cfgBypassTop = byT; cfgBypassBot = byB;
    #1;
    compareOut(hold);  // R2: no change before the clock edge
    pending.push_back(refModel(a, b, ct, cb, half, mid, byT, byB, tag));
  endtask

  task automatic flush();
    @(negedge clk);
    if (pending.size() > 0) compareOut(pending.pop_front());
  endtask

  function automatic string tagFor(logic half, logic mid, logic byT, logic byB);
    if (byT)  return "R6";
    if (byB)  return "R7";
    if (half) return "R5";
    if (mid)  return "R4";
    return "R3";
  endfunction

  initial begin
    expect_t zero;
    zero.sum = '0; zero.ct = 1'b0; zero.cb = 1'b0; zero.tag = "R1";
    rstN = 1'b0; opA = '0; opB = '0; cinTop = 1'b0; cinBot = 1'b0;
    cfgHalf = 1'b0; cfgStartMid = 1'b0; cfgBypassTop = 1'b0; cfgBypassBot = 1'b0;
    repeat (3) @(negedge clk);
    compareOut(zero);  // R1 reset state
    rstN = 1'b1;

    // R8: long carry runs through every group
    step('1, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    step('1, '0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    step('1, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    step({W{1'b1}}, {{(W-1){1'b0}}, 1'b1}, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // R3 directed: carry out of the top half only
    step(W'(20'h003FF), W'(20'h00001), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    // R6: bypassed top half passes cinTop into the bottom half
    step(W'(20'h003FF), W'(20'h003FF), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    step(W'(20'hFFC00), '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    // R5: split halves stay independent
    step(W'(20'h003FF), W'(20'h00001), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    step(W'(20'h00000), W'(20'h00000), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    // R7: bypassed bottom half forwards its entry carry
    step(W'(20'hFFFFF), W'(20'h00001), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    step(W'(20'h003FF), W'(20'h00001), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    // R4: mid start ignores cinTop in the top half
    step(W'(20'h003FF), W'(20'h00000), 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4");

    // Every configuration under random operands
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int n = 0; n < 30; n++) begin
        logic [W-1:0] ra, rb;
        logic h, m, bt, bb;
        ra = W'($urandom); rb = W'($urandom);
        h = cfg[0]; m = cfg[1]; bt = cfg[2]; bb = cfg[3];
        step(ra, rb, 1'($urandom), 1'($urandom), h, m, bt, bb, tagFor(h, m, bt, bb));
      end
    end

    // R1: reset in the middle of traffic clears asynchronously
    step('1, '1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    flush();
    #1 rstN = 1'b0;
    #1 compareOut(zero);
    @(negedge clk);
    compareOut(zero);
    rstN = 1'b1;
    step(W'(20'h12345), W'(20'h6789A), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    flush();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule